// File: doc/BRIEF.md
# Octal DTR Mode Switch Sequencer

This block moves a serial NOR flash between single-line extended SPI operation and octal double-transfer-rate operation, and then confirms that the change took effect. A single request pulse selects the direction. The sequencer then issues a short, fixed series of commands through the same command-request interface that a lower-level serial command engine accepts. Each command carries an opcode, an address byte count, an address, a dummy-cycle count, a data length, write data and a protocol select. The bit-level engine carries out each command and signals completion, an error, or the bytes it read.

Every switch ends by reading the identification bytes of the flash under the protocol the flash should now be using. The sequencer compares the first `ID_LEN` bytes of that read with an expected value. A one-cycle done pulse reports the result, with success and mismatch flags. The recorded mode output changes only when the verify succeeds. An error reported on any step stops the sequence at once.

Top module: `octal_mode_switcher`

## Requirements
- R1: After reset, `cmd_valid`, `seq_busy`, `seq_done`, `seq_ok`, `seq_mismatch` and `cur_mode` are all 0. `cur_mode` encodes 0 = extended single-line SPI and 1 = octal DTR. `cmd_proto` encodes 0 = 1-1-1 and 1 = octal DTR.
- R2: A request with `req_enable`=1 issues two register writes under protocol 0. Both use opcode 0x81, `ADDR_NBYTES` address bytes, no dummy cycles, one data byte and `cmd_write`=1. The first writes 0x14 (20 dummy cycles) to address 0x01. The second writes 0xE7 to address 0x00.
- R3: After the enable writes, the identification read uses opcode 0x9F with protocol 1, no address and 8 dummy cycles. Its length is `ID_LEN`, rounded up to an even count.
- R4: A request with `req_enable`=0 issues one write under protocol 1: opcode 0x81, address 0x00, `ADDR_NBYTES` address bytes, no dummy cycles and length 2. Byte 0xFF sits in `cmd_wdata[7:0]` and byte 0x1F in `cmd_wdata[15:8]`.
- R5: After the disable write, the identification read uses opcode 0x9F with protocol 0, no address, no dummy cycles and length `ID_LEN`.
- R6: In the cycle where the read completes without error, success is reported only if byte i of `rsp_data` (bits 8i+7..8i) equals byte i of `exp_id` for every i below `ID_LEN`. Bytes at or above `ID_LEN` have no effect. Otherwise `seq_mismatch` is set. The two flags are never 1 together.
- R7: When `cmd_err` accompanies `cmd_done` on any step, no further command is issued. The next cycle carries `seq_done` with `seq_ok`=0 and `seq_mismatch`=0.
- R8: `cur_mode` takes the requested direction only in the done cycle of a successful sequence. A failed or aborted sequence leaves it unchanged.
- R9: `seq_done` is high for exactly one cycle per accepted request. `seq_ok` and `seq_mismatch` hold their values until the next request is accepted.
- R10: A `req_valid` that arrives while `seq_busy` is high, including in the done cycle, is ignored. It issues no command and does not change the result or the mode.
- R11: While `cmd_valid` is high and `cmd_done` has not arrived, every command field stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a switch (taken only when idle) |
| req_enable | input | 1 | 1 = go to octal DTR, 0 = go back to single-line SPI |
| exp_id | input | 64 | Expected identification bytes, byte i at bits 8i+7..8i |
| cmd_valid | output | 1 | A command is presented to the engine |
| cmd_opcode | output | 8 | Command opcode |
| cmd_addr_bytes | output | 3 | Number of address bytes |
| cmd_addr | output | 32 | Address value |
| cmd_dummy | output | 5 | Dummy cycle count |
| cmd_len | output | 4 | Data byte count |
| cmd_wdata | output | 16 | Write bytes, first byte in [7:0] |
| cmd_write | output | 1 | 1 = data out, 0 = data in |
| cmd_proto | output | 1 | 0 = 1-1-1, 1 = octal DTR |
| cmd_done | input | 1 | Engine finished the presented command (one cycle) |
| cmd_err | input | 1 | Engine reports failure, valid with cmd_done |
| rsp_data | input | 64 | Bytes read, valid with cmd_done |
| seq_busy | output | 1 | A sequence is in progress |
| seq_done | output | 1 | One-cycle completion pulse |
| seq_ok | output | 1 | Last sequence verified the identification |
| seq_mismatch | output | 1 | Last sequence read a wrong identification |
| cur_mode | output | 1 | Recorded flash mode, 0 = SPI, 1 = octal DTR |

## Verification
The assertions assume that the engine raises `cmd_done` only while `cmd_valid` is high, holds it for a single cycle, and presents `cmd_err` and `rsp_data` in that same cycle. The bench's engine model follows this contract. It counts a fixed latency from the moment a command appears, pulses done once, and then restarts its count for the next command, which the sequencer presents in the following cycle. Requests are driven freely, including one deliberately placed in the middle of a busy sequence, because the block must tolerate them.

// File: rtl/odtr_pkg.sv
`timescale 1ns/1ps
package odtr_pkg;

  localparam int ID_MAX = 8;
  localparam int ID_BITS = 8 * ID_MAX;

  localparam logic [7:0] OP_WR_VOLATILE = 8'h81;
  localparam logic [7:0] OP_READ_IDENT  = 8'h9F;

  localparam logic [31:0] REG_IO_MODE   = 32'h0000_0000;
  localparam logic [31:0] REG_DUMMY_CFG = 32'h0000_0001;

  localparam logic [7:0] VAL_DUMMY_FAST = 8'd20;
  localparam logic [7:0] VAL_OCTAL_ON   = 8'hE7;
  localparam logic [7:0] VAL_SPI_ON     = 8'hFF;
  localparam logic [7:0] VAL_DUMMY_DEF  = 8'h1F;

  localparam logic [4:0] IDENT_DUMMY_OCT = 5'd8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [7:0]  opcode;
    logic [2:0]  addr_bytes;
    logic [31:0] addr;
    logic [4:0]  dummy;
    logic [3:0]  len;
    logic [15:0] wdata;
    logic        write;
    logic        octal;
  } cmd_t;

  // Identification read length: double-rate transfers move bytes in pairs.
  function automatic logic [3:0] ident_len(input int id_len, input logic octal);
    int n;
    n = id_len;
    if (octal && (id_len % 2) != 0) n = id_len + 1;
    return 4'(n);
  endfunction

  // Index of the final step (the identification read) per direction.
  function automatic logic [1:0] final_step(input logic to_octal);
    return to_octal ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/odtr_step_decode.sv
`timescale 1ns/1ps
module odtr_step_decode
  import odtr_pkg::*;
#(
  parameter int ID_LEN      = 3,
  parameter int ADDR_NBYTES = 4
) (
  input  logic       to_octal,
  input  logic [1:0] step,
  output cmd_t       cmd
);

  localparam logic [2:0] AB = 3'(ADDR_NBYTES);

  always_comb begin
    cmd = '0;
    if (to_octal) begin
      case (step)
        2'd0: begin
          cmd.opcode     = OP_WR_VOLATILE;
          cmd.addr_bytes = AB;
          cmd.addr       = REG_DUMMY_CFG;
          cmd.len        = 4'd1;
          cmd.wdata      = {8'h00, VAL_DUMMY_FAST};
          cmd.write      = 1'b1;
          cmd.octal      = 1'b0;
        end
        2'd1: begin
          cmd.opcode     = OP_WR_VOLATILE;
          cmd.addr_bytes = AB;
          cmd.addr       = REG_IO_MODE;
          cmd.len        = 4'd1;
          cmd.wdata      = {8'h00, VAL_OCTAL_ON};
          cmd.write      = 1'b1;
          cmd.octal      = 1'b0;
        end
        default: begin
          cmd.opcode = OP_READ_IDENT;
          cmd.dummy  = IDENT_DUMMY_OCT;
          cmd.len    = ident_len(ID_LEN, 1'b1);
          cmd.octal  = 1'b1;
        end
      endcase
    end else begin
      case (step)
        2'd0: begin
          cmd.opcode     = OP_WR_VOLATILE;
          cmd.addr_bytes = AB;
          cmd.addr       = REG_IO_MODE;
          cmd.len        = 4'd2;
          cmd.wdata      = {VAL_DUMMY_DEF, VAL_SPI_ON};
          cmd.write      = 1'b1;
          cmd.octal      = 1'b1;
        end
        default: begin
          cmd.opcode = OP_READ_IDENT;
          cmd.len    = ident_len(ID_LEN, 1'b0);
          cmd.octal  = 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/odtr_id_compare.sv
`timescale 1ns/1ps
module odtr_id_compare
  import odtr_pkg::*;
#(
  parameter int ID_LEN = 3
) (
  input  logic [ID_BITS-1:0] got,
  input  logic [ID_BITS-1:0] want,
  output logic               match
);

  localparam logic [ID_MAX-1:0] CARE = ID_MAX'((1 << ID_LEN) - 1);

  logic [ID_MAX-1:0] byte_ok;

  for (genvar i = 0; i < ID_MAX; i++) begin : g_byte
    assign byte_ok[i] = !CARE[i] || (got[8*i +: 8] == want[8*i +: 8]);
  end

  assign match = &byte_ok;

endmodule

// File: rtl/odtr_seq_fsm.sv
`timescale 1ns/1ps
module odtr_seq_fsm
  import odtr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_enable,
  input  logic       cmd_done,
  input  logic       cmd_err,
  input  logic       id_match,
  output logic       run,
  output logic [1:0] step,
  output logic       to_octal,
  output logic       busy,
  output logic       done,
  output logic       ok,
  output logic       mismatch,
  output logic       mode
);

  seq_state_e state_q;
  logic [1:0] step_q;
  logic       dir_q;

  // Named internal events
  logic accept_ev, abort_ev, advance_ev, verify_ev, at_final;

  assign at_final   = (step_q == final_step(dir_q));
  assign accept_ev  = (state_q == ST_IDLE) && req_valid;
  assign abort_ev   = (state_q == ST_RUN) && cmd_done && cmd_err;
  assign advance_ev = (state_q == ST_RUN) && cmd_done && !cmd_err && !at_final;
  assign verify_ev  = (state_q == ST_RUN) && cmd_done && !cmd_err && at_final;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      step_q   <= 2'd0;
      dir_q    <= 1'b0;
      ok       <= 1'b0;
      mismatch <= 1'b0;
      mode     <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept_ev) begin
          state_q  <= ST_RUN;
          step_q   <= 2'd0;
          dir_q    <= req_enable;
          ok       <= 1'b0;
          mismatch <= 1'b0;
        end
        ST_RUN: begin
          if (abort_ev) begin
            state_q <= ST_FIN;
          end else if (advance_ev) begin
            step_q <= step_q + 2'd1;
          end else if (verify_ev) begin
            state_q  <= ST_FIN;
            ok       <= id_match;
            mismatch <= !id_match;
            if (id_match) mode <= dir_q;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign run      = (state_q == ST_RUN);
  assign done     = (state_q == ST_FIN);
  assign busy     = (state_q != ST_IDLE);
  assign step     = step_q;
  assign to_octal = dir_q;

endmodule

// File: rtl/octal_mode_switcher.sv
`timescale 1ns/1ps
module octal_mode_switcher
  import odtr_pkg::*;
#(
  parameter int ID_LEN      = 3,
  parameter int ADDR_NBYTES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_enable,
  input  logic [63:0] exp_id,
  output logic        cmd_valid,
  output logic [7:0]  cmd_opcode,
  output logic [2:0]  cmd_addr_bytes,
  output logic [31:0] cmd_addr,
  output logic [4:0]  cmd_dummy,
  output logic [3:0]  cmd_len,
  output logic [15:0] cmd_wdata,
  output logic        cmd_write,
  output logic        cmd_proto,
  input  logic        cmd_done,
  input  logic        cmd_err,
  input  logic [63:0] rsp_data,
  output logic        seq_busy,
  output logic        seq_done,
  output logic        seq_ok,
  output logic        seq_mismatch,
  output logic        cur_mode
);

  logic       run_w, to_octal_w, match_w;
  logic [1:0] step_w;
  cmd_t       cmd_w;

  odtr_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_enable (req_enable),
    .cmd_done   (cmd_done),
    .cmd_err    (cmd_err),
    .id_match   (match_w),
    .run        (run_w),
    .step       (step_w),
    .to_octal   (to_octal_w),
    .busy       (seq_busy),
    .done       (seq_done),
    .ok         (seq_ok),
    .mismatch   (seq_mismatch),
    .mode       (cur_mode)
  );

  odtr_step_decode #(.ID_LEN(ID_LEN), .ADDR_NBYTES(ADDR_NBYTES)) u_dec (
    .to_octal (to_octal_w),
    .step     (step_w),
    .cmd      (cmd_w)
  );

  odtr_id_compare #(.ID_LEN(ID_LEN)) u_cmp (
    .got   (rsp_data),
    .want  (exp_id),
    .match (match_w)
  );

  assign cmd_valid      = run_w;
  assign cmd_opcode     = cmd_w.opcode;
  assign cmd_addr_bytes = cmd_w.addr_bytes;
  assign cmd_addr       = cmd_w.addr;
  assign cmd_dummy      = cmd_w.dummy;
  assign cmd_len        = cmd_w.len;
  assign cmd_wdata      = cmd_w.wdata;
  assign cmd_write      = cmd_w.write;
  assign cmd_proto      = cmd_w.octal;

endmodule

// File: rtl/octal_mode_switcher_chk.sv
`timescale 1ns/1ps
module octal_mode_switcher_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [7:0]  cmd_opcode,
  input logic [2:0]  cmd_addr_bytes,
  input logic [31:0] cmd_addr,
  input logic [4:0]  cmd_dummy,
  input logic [3:0]  cmd_len,
  input logic [15:0] cmd_wdata,
  input logic        cmd_write,
  input logic        cmd_proto,
  input logic        cmd_done,
  input logic        cmd_err,
  input logic        seq_done,
  input logic        seq_ok,
  input logic        seq_mismatch,
  input logic        cur_mode
);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);

  assert_mode_on_success_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode != $past(cur_mode)) |-> (seq_done && seq_ok));

  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_ok && seq_mismatch));

  assert_abort_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_done && cmd_err) |=> (seq_done && !seq_ok && !seq_mismatch && !cmd_valid));

  assert_cmd_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_opcode) && $stable(cmd_addr)
      && $stable(cmd_addr_bytes) && $stable(cmd_dummy) && $stable(cmd_len)
      && $stable(cmd_wdata) && $stable(cmd_write) && $stable(cmd_proto)));

  assert_octal_ident_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_opcode == 8'h9F && cmd_proto) |-> (cmd_dummy == 5'd8 && cmd_addr_bytes == 3'd0));

  assert_spi_ident_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_opcode == 8'h9F && !cmd_proto) |-> (cmd_dummy == 5'd0 && cmd_addr_bytes == 3'd0));

  assert_octal_write_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_write && cmd_proto) |-> (cmd_len == 4'd2));

endmodule

bind octal_mode_switcher octal_mode_switcher_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
  .cmd_addr_bytes(cmd_addr_bytes), .cmd_addr(cmd_addr), .cmd_dummy(cmd_dummy),
  .cmd_len(cmd_len), .cmd_wdata(cmd_wdata), .cmd_write(cmd_write), .cmd_proto(cmd_proto),
  .cmd_done(cmd_done), .cmd_err(cmd_err), .seq_done(seq_done), .seq_ok(seq_ok),
  .seq_mismatch(seq_mismatch), .cur_mode(cur_mode)
);

// File: tb/tb_octal_mode_switcher.sv
`timescale 1ns/1ps
module tb_octal_mode_switcher;

  localparam int ID_LEN = 3;
  localparam int ADDR_NBYTES = 4;
  localparam int LAT = 3;

  typedef struct packed {
    logic [7:0] op; logic [2:0] ab; logic [31:0] addr; logic [4:0] dm;
    logic [3:0] len; logic [15:0] wd; logic wr; logic pr;
  } xcmd_t;
  typedef struct packed { logic ok; logic mis; logic mode; } xres_t;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req_valid = 1'b0, req_enable = 1'b0;
  logic [63:0] exp_id = '0, flash_id = '0;
  logic cmd_valid, cmd_write, cmd_proto, cmd_done, cmd_err;
  logic [7:0] cmd_opcode; logic [2:0] cmd_addr_bytes; logic [31:0] cmd_addr;
  logic [4:0] cmd_dummy; logic [3:0] cmd_len; logic [15:0] cmd_wdata;
  logic seq_busy, seq_done, seq_ok, seq_mismatch, cur_mode;

  octal_mode_switcher #(.ID_LEN(ID_LEN), .ADDR_NBYTES(ADDR_NBYTES)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_enable(req_enable),
    .exp_id(exp_id), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
    .cmd_addr_bytes(cmd_addr_bytes), .cmd_addr(cmd_addr), .cmd_dummy(cmd_dummy),
    .cmd_len(cmd_len), .cmd_wdata(cmd_wdata), .cmd_write(cmd_write),
    .cmd_proto(cmd_proto), .cmd_done(cmd_done), .cmd_err(cmd_err),
    .rsp_data(flash_id), .seq_busy(seq_busy), .seq_done(seq_done),
    .seq_ok(seq_ok), .seq_mismatch(seq_mismatch), .cur_mode(cur_mode)
  );

  xcmd_t cmd_q[$]; xres_t res_q[$]; string tag_q[$];
  int checks = 0, fails = 0, results_seen = 0;
  int cmd_idx = 0, err_at = -1, cnt = 0;
  logic model_mode = 1'b0;
  bit finished = 0;

  task automatic chk(input bit cond, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_test();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  function automatic string cmd_tag(input xcmd_t c);
    if (c.op == 8'h9F) return c.pr ? "R3 octal ident read" : "R5 spi ident read";
    return c.pr ? "R4 disable write" : "R2 enable write";
  endfunction

  // Engine model + command scoreboard monitor
  always @(negedge clk) begin
    xcmd_t got, e;
    if (!rst_n) begin
      cmd_done = 1'b0; cmd_err = 1'b0; cnt = 0;
    end else if (cmd_done) begin
      cmd_done = 1'b0; cmd_err = 1'b0; cnt = 0;
    end else if (cmd_valid) begin
      if (cnt == LAT) begin
        cmd_done = 1'b1;
        cmd_err = (cmd_idx == err_at);
        got = {cmd_opcode, cmd_addr_bytes, cmd_addr, cmd_dummy, cmd_len, cmd_wdata, cmd_write, cmd_proto};
        if (cmd_q.size() == 0) chk(1'b0, "R7/R10 unexpected command", 128'(got), 128'(0));
        else begin
          e = cmd_q.pop_front();
          chk(got == e, cmd_tag(e), 128'(got), 128'(e));
        end
        cmd_idx++;
      end else cnt++;
    end
  end

  // Result monitor
  always @(negedge clk) begin
    xres_t r; string t;
    if (rst_n && seq_done) begin
      if (res_q.size() == 0) chk(1'b0, "R9 unexpected done", 128'(1), 128'(0));
      else begin
        r = res_q.pop_front(); t = tag_q.pop_front();
        chk({seq_ok, seq_mismatch} == {r.ok, r.mis}, t, 128'({seq_ok, seq_mismatch}), 128'({r.ok, r.mis}));
        chk(cur_mode == r.mode, "R8 mode at done", 128'(cur_mode), 128'(r.mode));
      end
      results_seen++;
    end
  end

  // Driver: pushes expected commands and result, then fires the request
  task automatic run_seq(input bit en, input logic [63:0] want, input logic [63:0] have,
                         input int err_step, input bit poke);
    xcmd_t c[3]; int n; bit match; xres_t r; int target;
    int oct_len;
    oct_len = (ID_LEN % 2 != 0) ? ID_LEN + 1 : ID_LEN;
    match = 1;
    for (int i = 0; i < ID_LEN; i++) if (want[8*i +: 8] != have[8*i +: 8]) match = 0;
    if (en) begin
      n = 3;
      c[0] = {8'h81, 3'(ADDR_NBYTES), 32'h1, 5'd0, 4'd1, 16'h0014, 1'b1, 1'b0};
      c[1] = {8'h81, 3'(ADDR_NBYTES), 32'h0, 5'd0, 4'd1, 16'h00E7, 1'b1, 1'b0};
      c[2] = {8'h9F, 3'd0, 32'h0, 5'd8, 4'(oct_len), 16'h0000, 1'b0, 1'b1};
    end else begin
      n = 2;
      c[0] = {8'h81, 3'(ADDR_NBYTES), 32'h0, 5'd0, 4'd2, 16'h1FFF, 1'b1, 1'b1};
      c[1] = {8'h9F, 3'd0, 32'h0, 5'd0, 4'(ID_LEN), 16'h0000, 1'b0, 1'b0};
      c[2] = '0;
    end
    for (int k = 0; k < n; k++) begin
      cmd_q.push_back(c[k]);
      if (k == err_step) break;
    end
    if (err_step >= 0) begin
      r = {1'b0, 1'b0, model_mode}; tag_q.push_back("R7 error aborts");
    end else begin
      if (match) model_mode = en;
      r = {match, !match, model_mode}; tag_q.push_back("R6 identification compare");
    end
    res_q.push_back(r);
    exp_id = want; flash_id = have; err_at = err_step; cmd_idx = 0;
    target = results_seen + 1;
    @(negedge clk); req_valid = 1'b1; req_enable = en;
    @(negedge clk); req_valid = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      req_valid = 1'b1; req_enable = !en;
      @(negedge clk); req_valid = 1'b0;
    end
    while (results_seen < target) @(negedge clk);
    @(negedge clk);
    chk(cmd_q.size() == 0, "R7 all expected commands issued", 128'(cmd_q.size()), 128'(0));
    chk(!seq_done && !seq_busy, "R9 done is a single pulse", 128'({seq_done, seq_busy}), 128'(0));
    chk({seq_ok, seq_mismatch} == {r.ok, r.mis}, "R9 flags held", 128'({seq_ok, seq_mismatch}), 128'({r.ok, r.mis}));
    chk(cur_mode == model_mode, "R8 mode after sequence", 128'(cur_mode), 128'(model_mode));
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [63:0] id;
    id = 64'h0000_0000_001A_5B2C;
    repeat (3) @(negedge clk);
    chk({cmd_valid, seq_busy, seq_done, seq_ok, seq_mismatch, cur_mode} == 6'b0,
        "R1 reset state", 128'({cmd_valid, seq_busy, seq_done, seq_ok, seq_mismatch, cur_mode}), 128'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!cmd_valid && !cur_mode, "R1 idle after reset", 128'({cmd_valid, cur_mode}), 128'(0));

    run_seq(1'b1, id, id, -1, 1'b0);                          // R2 R3 enable ok
    run_seq(1'b0, id, id ^ 64'h0000_0100, -1, 1'b0);          // R6 mismatch, R8 mode kept
    run_seq(1'b0, id, id, 0, 1'b0);                           // R7 abort on write
    run_seq(1'b0, id, id | 64'hAB00_0000, -1, 1'b1);          // R6 byte beyond ID_LEN, R10 poke
    run_seq(1'b1, id, id, 1, 1'b0);                           // R7 abort on second write
    run_seq(1'b1, id, id, 2, 1'b0);                           // R7 abort on read
    run_seq(1'b1, id, id ^ 64'h0080_0000, -1, 1'b0);          // R6 mismatch on last byte
    run_seq(1'b1, id, id, -1, 1'b1);                          // R10 poke, enable ok
    chk(res_q.size() == 0 && cmd_q.size() == 0, "R10 no stray work", 128'(res_q.size() + cmd_q.size()), 128'(0));
    finish_test();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    finish_test();
  end

endmodule